// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache that sits between an address source and a page-table walker. A lookup presents an address-space tag, a virtual address and an access type. The virtual page number (every bit above the page offset) is compared against all stored entries at once. The result is returned combinationally in the same cycle. On a permitted match the block forms the physical address from the stored frame number and the untouched page offset. On a denied match it raises a protection fault. When nothing matches it raises a miss, so that an outside walker can fetch the translation and write it back through the fill port.

Every entry holds a valid flag, an address-space tag, a page number, a frame number and three permission bits. Because a match needs both the tag and the page number to agree, translations of several processes can stay resident across a context switch. A global flush clears every entry. A tag-selective flush clears only the entries that carry one given tag. Fills pick their slot by a fixed order: the existing copy of the same translation, then the lowest free slot, then a rotating victim.

Top module: `tlb_tagged`

## Requirements
- R1: While `lk_valid` is low, `lk_hit`, `lk_miss` and `lk_fault` are all 0.
- R2: An entry matches a lookup only if it is valid, its tag equals `lk_asid` and its page number equals `lk_vaddr[31:12]`. The lookup outputs reflect the match in the same cycle.
- R3: On a permitted match, `lk_hit` is 1, `lk_paddr` is {stored frame, `lk_vaddr[11:0]`} and `lk_perm` shows the entry's permission bits.
- R4: With no matching entry, a valid lookup gives `lk_miss`=1, `lk_hit`=0, `lk_fault`=0, `lk_paddr`=0 and `lk_perm`=0.
- R5: Permission bits are bit0=read, bit1=write, bit2=execute. The access codes are 0=read, 1=write and 2=execute, and each needs its bit. Code 3 is never permitted. A denied match gives `lk_fault`=1, `lk_hit`=0, `lk_miss`=0, `lk_paddr`=0, with `lk_perm` still showing the entry's bits.
- R6: A fill is written on the rising edge where `fill_en` is high. It is visible to lookups from the following cycle.
- R7: A fill whose tag and page number equal those of a valid entry overwrites that entry in place and does not move the rotating victim pointer.
- R8: Otherwise, a fill goes to the lowest-indexed invalid entry.
- R9: When all entries are valid and none matches, a fill replaces the entry at the rotating pointer. The pointer starts at 0, advances by one for each such replacement and wraps after the last entry.
- R10: `flush_all` invalidates every entry from the next cycle.
- R11: `flush_asid_en` invalidates, from the next cycle, exactly the entries whose tag equals `flush_asid`.
- R12: A fill presented in the same cycle as either flush is discarded.
- R13: After reset, every entry is invalid and the rotating pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 8 | Address-space tag of the lookup |
| lk_vaddr | input | 32 | Virtual address |
| lk_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 none |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Match found but access denied |
| lk_paddr | output | 32 | Physical address on a hit, else 0 |
| lk_perm | output | 3 | Permission bits of the matching entry |
| fill_en | input | 1 | Install an entry |
| fill_asid | input | 8 | Tag of the entry to install |
| fill_vpn | input | 20 | Page number of the entry to install |
| fill_pfn | input | 20 | Frame number of the entry to install |
| fill_perm | input | 3 | Permission bits of the entry to install |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate entries with tag `flush_asid` |
| flush_asid | input | 8 | Tag selected for invalidation |

## Verification
Lookup results are combinational. The bench therefore drives each lookup just after a falling edge and compares all five result ports 1 ns later, within the same cycle. Fills and flushes take effect on a rising edge, so the bench holds them for exactly one rising edge and updates its own table of entries only after that edge. Every later lookup is then judged against the table as it stands after the edge. Victim order, the free-slot preference and in-place refills are inferred from which earlier translations still hit after a series of fills.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

   localparam int PERM_W = 3;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_NONE  = 2'd3
   } acc_e;

   typedef logic [PERM_W-1:0] perm_t;

endpackage

// File: rtl/tlb_perm_check.sv
`timescale 1ns/1ps
module tlb_perm_check
   import tlb_pkg::*;
(
   input  logic [1:0] acc,
   input  perm_t      perm,
   output logic       allow
);

   acc_e kind;
   assign kind = acc_e'(acc);

   always_comb begin
      unique case (kind)
         ACC_READ:  allow = perm[PERM_RD];
         ACC_WRITE: allow = perm[PERM_WR];
         ACC_EXEC:  allow = perm[PERM_EX];
         default:   allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
module tlb_entry_array
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   // lookup side
   input  logic [ASID_W-1:0]  rd_asid,
   input  logic [VPN_W-1:0]   rd_vpn,
   output logic [ENTRIES-1:0] rd_match,
   output logic [PFN_W-1:0]   rd_pfn,
   output perm_t              rd_perm,
   // write side
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ASID_W-1:0]  wr_asid,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PFN_W-1:0]   wr_pfn,
   input  perm_t              wr_perm,
   output logic [ENTRIES-1:0] wr_match,
   // invalidation
   input  logic               inv_all,
   input  logic               inv_tag_en,
   input  logic [ASID_W-1:0]  inv_tag,
   output logic [ENTRIES-1:0] valid_vec
);

   logic [ENTRIES-1:0] valid_q;
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];
   perm_t              perm_q [ENTRIES];

   // valid flags carry reset; flush beats a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (inv_all)
               valid_q[i] <= 1'b0;
            else if (inv_tag_en && asid_q[i] == inv_tag)
               valid_q[i] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(i))
               valid_q[i] <= 1'b1;
         end
      end
   end

   // payload needs no reset: it is never read while invalid
   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (wr_en && wr_idx == IDX_W'(i)) begin
            asid_q[i] <= wr_asid;
            vpn_q[i]  <= wr_vpn;
            pfn_q[i]  <= wr_pfn;
            perm_q[i] <= wr_perm;
         end
      end
   end

   // one comparator pair per entry
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign rd_match[g] = valid_q[g] && (asid_q[g] == rd_asid) && (vpn_q[g] == rd_vpn);
      assign wr_match[g] = valid_q[g] && (asid_q[g] == wr_asid) && (vpn_q[g] == wr_vpn);
   end

   // at most one match, so an OR of gated payloads is the read mux
   always_comb begin
      rd_pfn  = '0;
      rd_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (rd_match[i]) begin
            rd_pfn  = rd_pfn  | pfn_q[i];
            rd_perm = rd_perm | perm_q[i];
         end
      end
   end

   assign valid_vec = valid_q;

   // R7
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_match));

   // R10
   flush_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (valid_q == '0));

   // R11
   flush_tag_keeps_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_tag_en && !inv_all && !wr_en) |=> ($countones(valid_q) <= $countones($past(valid_q))));

endmodule

// File: rtl/tlb_victim_sel.sv
`timescale 1ns/1ps
module tlb_victim_sel #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_go,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] same_vec,
   output logic [IDX_W-1:0]   slot
);

   logic [IDX_W-1:0] ptr_q;
   logic             has_same;
   logic             has_free;
   logic [IDX_W-1:0] same_idx;
   logic [IDX_W-1:0] free_idx;

   function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
      lowest_set = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (v[i]) lowest_set = IDX_W'(i);
   endfunction

   assign has_same = |same_vec;
   assign has_free = ~&valid_vec;
   assign same_idx = lowest_set(same_vec);
   assign free_idx = lowest_set(~valid_vec);

   always_comb begin
      if (has_same)
         slot = same_idx;
      else if (has_free)
         slot = free_idx;
      else
         slot = ptr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (fill_go && !has_same && !has_free) begin
         if (ptr_q == IDX_W'(ENTRIES - 1))
            ptr_q <= '0;
         else
            ptr_q <= ptr_q + 1'b1;
      end
   end

   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_go |=> $stable(ptr_q));

   // R8
   free_slot_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && !has_same && has_free) |-> !valid_vec[slot]);

endmodule

// File: rtl/tlb_tagged.sv
`timescale 1ns/1ps
module tlb_tagged
   import tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PFN_W     = 20,
   parameter int ASID_W    = 8,
   parameter int ENTRIES   = 8,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PA_W     = PFN_W + PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [1:0]        lk_acc,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_fault,
   output logic [PA_W-1:0]   lk_paddr,
   output logic [2:0]        lk_perm,
   input  logic              fill_en,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [2:0]        fill_perm,
   input  logic              flush_all,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid
);

   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("tlb_tagged: PAGE_BITS must lie between 1 and VA_W-1");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("tlb_tagged: ENTRIES must be at least 2");
   end
   if (PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("tlb_tagged: PFN_W and ASID_W must be positive");
   end

   logic [VPN_W-1:0]     lk_vpn;
   logic [PAGE_BITS-1:0] lk_off;
   logic [ENTRIES-1:0]   rd_match;
   logic [ENTRIES-1:0]   wr_match;
   logic [ENTRIES-1:0]   valid_vec;
   logic [PFN_W-1:0]     rd_pfn;
   perm_t                rd_perm;
   logic                 found;
   logic                 allow;
   logic                 fill_go;
   logic [IDX_W-1:0]     slot;

   assign lk_vpn  = lk_vaddr[VA_W-1:PAGE_BITS];
   assign lk_off  = lk_vaddr[PAGE_BITS-1:0];
   assign fill_go = fill_en && !flush_all && !flush_asid_en;

   tlb_entry_array #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .ASID_W  (ASID_W),
      .PFN_W   (PFN_W)
   ) array_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_asid    (lk_asid),
      .rd_vpn     (lk_vpn),
      .rd_match   (rd_match),
      .rd_pfn     (rd_pfn),
      .rd_perm    (rd_perm),
      .wr_en      (fill_go),
      .wr_idx     (slot),
      .wr_asid    (fill_asid),
      .wr_vpn     (fill_vpn),
      .wr_pfn     (fill_pfn),
      .wr_perm    (fill_perm),
      .wr_match   (wr_match),
      .inv_all    (flush_all),
      .inv_tag_en (flush_asid_en),
      .inv_tag    (flush_asid),
      .valid_vec  (valid_vec)
   );

   tlb_victim_sel #(
      .ENTRIES (ENTRIES)
   ) victim_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_go   (fill_go),
      .valid_vec (valid_vec),
      .same_vec  (wr_match),
      .slot      (slot)
   );

   tlb_perm_check perm_i (
      .acc   (lk_acc),
      .perm  (rd_perm),
      .allow (allow)
   );

   assign found    = |rd_match;
   assign lk_hit   = lk_valid && found && allow;
   assign lk_fault = lk_valid && found && !allow;
   assign lk_miss  = lk_valid && !found;
   assign lk_paddr = lk_hit ? {rd_pfn, lk_off} : '0;
   assign lk_perm  = (lk_valid && found) ? rd_perm : '0;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

   // R5
   outcome_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lk_hit, lk_miss, lk_fault}));

   // R3
   offset_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]));

   // R12
   fill_dropped_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && flush_all) |=> (valid_vec == '0));

endmodule

// File: tb/tlb_tagged_tb_top.sv
`timescale 1ns/1ps
module tlb_tagged_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [7:0]  lk_asid = '0;
   logic [31:0] lk_vaddr = '0;
   logic [1:0]  lk_acc = '0;
   logic        lk_hit, lk_miss, lk_fault;
   logic [31:0] lk_paddr;
   logic [2:0]  lk_perm;
   logic        fill_en = 1'b0;
   logic [7:0]  fill_asid = '0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_pfn = '0;
   logic [2:0]  fill_perm = '0;
   logic        flush_all = 1'b0;
   logic        flush_asid_en = 1'b0;
   logic [7:0]  flush_asid = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench-side table
   bit          mv  [8];
   logic [7:0]  ma  [8];
   logic [19:0] mvp [8];
   logic [19:0] mpf [8];
   logic [2:0]  mpr [8];
   int          mptr = 0;
   logic [7:0]  used_a [64];
   logic [19:0] used_v [64];
   int          n_used = 0;

   always #2 clk = ~clk;

   tlb_tagged dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
      .lk_paddr(lk_paddr), .lk_perm(lk_perm),
      .fill_en(fill_en), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
      .fill_pfn(fill_pfn), .fill_perm(fill_perm),
      .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
   );

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
      end
   end

   task automatic model_fill(input [7:0] a, input [19:0] v, input [19:0] p, input [2:0] pr);
      int k = -1;
      for (int i = 0; i < 8; i++) if (mv[i] && ma[i] == a && mvp[i] == v) k = i;   // R7
      if (k < 0) for (int i = 7; i >= 0; i--) if (!mv[i]) k = i;                    // R8
      if (k < 0) begin k = mptr; mptr = (mptr + 1) % 8; end                          // R9
      mv[k] = 1'b1; ma[k] = a; mvp[k] = v; mpf[k] = p; mpr[k] = pr;
   endtask

   task automatic do_op(input bit fe, input [7:0] a, input [19:0] v, input [19:0] p,
                        input [2:0] pr, input bit fa, input bit ft, input [7:0] ftag);
      @(negedge clk);
      fill_en = fe; fill_asid = a; fill_vpn = v; fill_pfn = p; fill_perm = pr;
      flush_all = fa; flush_asid_en = ft; flush_asid = ftag;
      @(posedge clk);
      #1;
      fill_en = 1'b0; flush_all = 1'b0; flush_asid_en = 1'b0;
      if (fa) begin
         for (int i = 0; i < 8; i++) mv[i] = 1'b0;
      end else if (ft) begin
         for (int i = 0; i < 8; i++) if (ma[i] == ftag) mv[i] = 1'b0;
      end else if (fe) begin
         model_fill(a, v, p, pr);
      end
      if (fe && n_used < 64) begin
         used_a[n_used] = a; used_v[n_used] = v; n_used++;
      end
   endtask

   task automatic look(input [7:0] a, input [31:0] va, input [1:0] acc, input string rq);
      bit eh = 0, em = 0, ef = 0;
      logic [31:0] ep = '0;
      logic [2:0]  eperm = '0;
      int k = -1;
      @(negedge clk);
      lk_valid = 1'b1; lk_asid = a; lk_vaddr = va; lk_acc = acc;
      #1;
      for (int i = 0; i < 8; i++) if (mv[i] && ma[i] == a && mvp[i] == va[31:12]) k = i;
      if (k < 0) em = 1;
      else begin
         eperm = mpr[k];
         if (acc != 2'd3 && mpr[k][acc]) begin eh = 1; ep = {mpf[k], va[11:0]}; end
         else ef = 1;
      end
      checks++;
      if (lk_hit !== eh || lk_miss !== em || lk_fault !== ef || lk_paddr !== ep || lk_perm !== eperm) begin
         errors++;
         $display("FAIL %s: asid=%h va=%h acc=%0d actual h/m/f=%b%b%b pa=%h perm=%b expected h/m/f=%b%b%b pa=%h perm=%b",
                  rq, a, va, acc, lk_hit, lk_miss, lk_fault, lk_paddr, lk_perm, eh, em, ef, ep, eperm);
      end
      lk_valid = 1'b0;
   endtask

   task automatic check_all(input string rq);
      for (int u = 0; u < n_used; u++) look(used_a[u], {used_v[u], 12'h5A5}, 2'd0, rq);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) mv[i] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R13: empty after reset
      look(8'h01, 32'h0010_0000, 2'd0, "R13");
      look(8'h00, 32'h0000_0000, 2'd2, "R4");

      // R6: eight fills with every permission pattern
      for (int i = 0; i < 8; i++)
         do_op(1, 8'h01, 20'h00100 + 20'(i * 17), 20'hA0000 + 20'(i), 3'(i), 0, 0, 8'h00);

      // R3 R5: every entry, every access code, three offsets
      for (int i = 0; i < 8; i++)
         for (int c = 0; c < 4; c++) begin
            look(8'h01, {20'h00100 + 20'(i * 17), 12'h000}, 2'(c), "R5");
            look(8'h01, {20'h00100 + 20'(i * 17), 12'hFFF}, 2'(c), "R3");
            look(8'h01, {20'h00100 + 20'(i * 17), 12'(i * 291)}, 2'(c), "R3");
         end

      // R2: tag and page must both agree
      look(8'h02, 32'h0010_0000, 2'd0, "R2");
      look(8'h01, 32'h0010_1000, 2'd0, "R2");

      // R1: no outcome without a request
      @(negedge clk);
      lk_valid = 1'b0; lk_asid = 8'h01; lk_vaddr = 32'h0017_7000; lk_acc = 2'd2;
      #1;
      checks++;
      if (lk_hit || lk_miss || lk_fault) begin
         errors++;
         $display("FAIL R1: actual h/m/f=%b%b%b expected 000", lk_hit, lk_miss, lk_fault);
      end

      // R7: refill in place
      do_op(1, 8'h01, 20'h00155, 20'hBBBBB, 3'b111, 0, 0, 8'h00);
      look(8'h01, 32'h0015_5123, 2'd1, "R7");

      // R9: rotating victims
      for (int i = 0; i < 3; i++)
         do_op(1, 8'h03, 20'h00700 + 20'(i), 20'hC0000 + 20'(i), 3'b001, 0, 0, 8'h00);
      check_all("R9");

      // R11: tag-selective flush
      do_op(0, 8'h00, 20'h0, 20'h0, 3'b000, 0, 1, 8'h01);
      check_all("R11");

      // R8: free slots before the pointer, then rotation resumes
      for (int i = 0; i < 6; i++)
         do_op(1, 8'h04, 20'h00900 + 20'(i), 20'hD0000 + 20'(i), 3'b011, 0, 0, 8'h00);
      check_all("R8");

      // R12: fill alongside a flush is dropped
      do_op(1, 8'h05, 20'h0ABCD, 20'hE0000, 3'b111, 0, 1, 8'h77);
      look(8'h05, 32'h0ABC_D000, 2'd0, "R12");
      do_op(1, 8'h05, 20'h0ABCE, 20'hE0001, 3'b111, 1, 0, 8'h00);
      look(8'h05, 32'h0ABC_E000, 2'd0, "R12");

      // R10: everything gone
      check_all("R10");

      // R9: wrap of the pointer over many replacements
      for (int i = 0; i < 18; i++)
         do_op(1, 8'h06, 20'h03000 + 20'(i), 20'hF0000 + 20'(i), 3'b101, 0, 0, 8'h00);
      check_all("R9");

      done = 1'b1;
      summary();
   end

endmodule